// File: doc/BRIEF.md
# Add/Subtract Accumulator with Counting Destination

This block is a small arithmetic datapath built around two registers: an operand register that holds B and an accumulator that holds D. A ripple-carry adder made of single-bit full adders always forms either D + B or D − B. One mode input chooses which. That input flips every B bit through an XOR stage, and it also drives the adder's carry-in, which gives two's-complement subtraction.

The accumulator has two controls. A load strobe captures the adder result on the clock edge. An increment strobe steps D by one, and the adder takes no part in that step. When both strobes are high, the load wins. The adder's final carry is a combinational output and is never stored.

The operand register is written from an external port on its own strobe. A synchronous reset clears both registers. The datapath width is a parameter and defaults to four bits.

Top module: `addsub_accum`

## Requirements
- R1: While `rst` is high at a rising clock edge, both the accumulator and the operand register become zero on that edge.
- R2: With `mode_sub` = 0 and `ld_acc` = 1, the accumulator takes (D + B) mod 2^W on the next edge. Any carry out of the top bit is dropped from D.
- R3: With `mode_sub` = 1 and `ld_acc` = 1, the accumulator takes (D − B) mod 2^W on the next edge. This is D + ~B + 1.
- R4: `carry_out` is combinational from the current D, B and `mode_sub`. For `mode_sub` = 0 it is 1 exactly when D + B ≥ 2^W. For `mode_sub` = 1 it is 1 exactly when D ≥ B as unsigned numbers, meaning no borrow.
- R5: With `inc_acc` = 1 and `ld_acc` = 0, the accumulator takes D + 1 on the next edge whatever `mode_sub` and the B value are. All ones wraps to zero.
- R6: When `ld_acc` and `inc_acc` are both 1, the adder result is loaded and the increment is ignored.
- R7: With `ld_acc` = 0 and `inc_acc` = 0, the accumulator keeps its value, whatever `mode_sub`, `b_in` and `ld_b` are.
- R8: With `ld_b` = 1 the operand register takes `b_in` on the next edge. With `ld_b` = 0 it keeps its value whatever `b_in` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sub | input | 1 | 0 selects D + B, 1 selects D − B |
| ld_acc | input | 1 | Load adder result into the accumulator |
| inc_acc | input | 1 | Increment the accumulator |
| ld_b | input | 1 | Load `b_in` into the operand register |
| b_in | input | W | New operand value |
| acc_q | output | W | Accumulator contents D |
| carry_out | output | 1 | Final carry of the ripple adder |

## Verification
The operand register has no output of its own, so it is the hardest state to observe. The bench sees B only through `carry_out` and through what a later load writes into D. Each B update, and each cycle where a changed `b_in` should be ignored, is therefore followed by a load or a carry check whose expected value depends on B. Reaching the increment wrap needs the accumulator at all ones. The stimulus gets there by repeated increments, with `mode_sub` and `b_in` kept busy, until the reference model reads all ones, and then one more increment.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

    // Default datapath width.
    parameter int unsigned DW = 4;

    // Operation selected for the accumulator on a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_INC  = 2'd2
    } acc_act_e;

endpackage

// File: rtl/addsub_operand_xor.sv
`timescale 1ns/1ps
module addsub_operand_xor #(
    parameter int unsigned W = addsub_pkg::DW
) (
    input  logic [W-1:0] b_raw,
    input  logic         invert,
    output logic [W-1:0] b_cond
);

    // One XOR gate per bit: pass-through when invert = 0, complement when 1.
    for (genvar gi = 0; gi < W; gi++) begin : g_xor
        assign b_cond[gi] = b_raw[gi] ^ invert;
    end

endmodule

// File: rtl/addsub_full_adder.sv
`timescale 1ns/1ps
module addsub_full_adder (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    logic p;

    always_comb begin
        p  = a ^ b;
        s  = p ^ ci;
        co = (a & b) | (p & ci);
    end

endmodule

// File: rtl/addsub_ripple.sv
`timescale 1ns/1ps
module addsub_ripple #(
    parameter int unsigned W = addsub_pkg::DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int unsigned NC = W + 1;

    logic [NC-1:0] chain;

    assign chain[0] = cin;

    // Each stage's carry-out feeds the next stage's carry-in.
    for (genvar gi = 0; gi < W; gi++) begin : g_stage
        addsub_full_adder u_fa (
            .a  (a[gi]),
            .b  (b[gi]),
            .ci (chain[gi]),
            .s  (sum[gi]),
            .co (chain[gi+1])
        );
    end

    assign cout = chain[NC-1];

endmodule

// File: rtl/addsub_breg.sv
`timescale 1ns/1ps
module addsub_breg #(
    parameter int unsigned W = addsub_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } breg_t;

    breg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = '0;
        end else if (ld) begin
            st_d.val = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.val;

    a_r8_b_load : assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(din)));

    a_r8_b_hold : assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));

    a_r1_b_reset : assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/addsub_counter.sv
`timescale 1ns/1ps
module addsub_counter #(
    parameter int unsigned W = addsub_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    import addsub_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] val;
    } cnt_t;

    cnt_t     st_d, st_q;
    acc_act_e act;

    // Load outranks increment; neither means hold.
    always_comb begin
        if (ld) begin
            act = ACT_LOAD;
        end else if (inc) begin
            act = ACT_INC;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = '0;
        end else begin
            unique case (act)
                ACT_LOAD: st_d.val = din;
                ACT_INC:  st_d.val = st_q.val + ONE;
                default:  st_d.val = st_q.val;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.val;

    a_r6_load_wins : assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(din)));

    a_r5_increment : assert property (@(posedge clk) disable iff (rst)
        (!ld && inc) |=> (q == W'($past(q) + ONE)));

    a_r7_hold : assert property (@(posedge clk) disable iff (rst)
        (!ld && !inc) |=> $stable(q));

    a_r1_acc_reset : assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/addsub_accum.sv
`timescale 1ns/1ps
module addsub_accum #(
    parameter int unsigned W = addsub_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_sub,
    input  logic         ld_acc,
    input  logic         inc_acc,
    input  logic         ld_b,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] acc_q,
    output logic         carry_out
);

    logic [W-1:0] b_q;
    logic [W-1:0] b_cond;
    logic [W-1:0] sum;

    addsub_breg #(.W(W)) u_breg (
        .clk (clk),
        .rst (rst),
        .ld  (ld_b),
        .din (b_in),
        .q   (b_q)
    );

    addsub_operand_xor #(.W(W)) u_xor (
        .b_raw  (b_q),
        .invert (mode_sub),
        .b_cond (b_cond)
    );

    // The mode bit doubles as carry-in: D + ~B + 1 when subtracting.
    addsub_ripple #(.W(W)) u_add (
        .a    (acc_q),
        .b    (b_cond),
        .cin  (mode_sub),
        .sum  (sum),
        .cout (carry_out)
    );

    addsub_counter #(.W(W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .ld  (ld_acc),
        .inc (inc_acc),
        .din (sum),
        .q   (acc_q)
    );

    a_r2_add_result : assert property (@(posedge clk) disable iff (rst)
        !mode_sub |-> ({carry_out, sum} == ({1'b0, acc_q} + {1'b0, b_q})));

    a_r3_sub_result : assert property (@(posedge clk) disable iff (rst)
        mode_sub |-> (sum == W'(acc_q - b_q)));

    a_r4_no_borrow : assert property (@(posedge clk) disable iff (rst)
        mode_sub |-> (carry_out == (acc_q >= b_q)));

endmodule

// File: tb/addsub_accum_tb.sv
`timescale 1ns/1ps
module addsub_accum_tb;

    localparam int W = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_sub = 1'b0;
    logic         ld_acc = 1'b0;
    logic         inc_acc = 1'b0;
    logic         ld_b = 1'b0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] acc_q;
    logic         carry_out;

    int n_run  = 0;
    int n_fail = 0;
    int md = 0;   // reference accumulator
    int mb = 0;   // reference operand register
    bit done = 1'b0;

    always #2 clk = ~clk;

    addsub_accum #(.W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_sub  (mode_sub),
        .ld_acc    (ld_acc),
        .inc_acc   (inc_acc),
        .ld_b      (ld_b),
        .b_in      (b_in),
        .acc_q     (acc_q),
        .carry_out (carry_out)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one cycle; check carry before the edge and the accumulator after it.
    task automatic apply(input bit l, input bit i, input bit lb, input int bv,
                         input bit m, input string req);
        int s;
        int c;
        @(negedge clk);
        ld_acc = l; inc_acc = i; ld_b = lb; b_in = W'(bv); mode_sub = m;
        #1;
        if (m) begin
            s = (md - mb) & MASK;
            c = (md >= mb) ? 1 : 0;
        end else begin
            s = (md + mb) & MASK;
            c = ((md + mb) > MASK) ? 1 : 0;
        end
        chk({req, " R4 carry"}, int'(carry_out), c);
        @(posedge clk);
        #1;
        if (l) md = s;
        else if (i) md = (md + 1) & MASK;
        if (lb) mb = bv & MASK;
        chk({req, " acc"}, int'(acc_q), md);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; ld_b = 1'b1; b_in = 4'hA; ld_acc = 1'b1; inc_acc = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 acc after reset", int'(acc_q), 0);
        @(negedge clk);
        rst = 1'b0; ld_b = 1'b0; ld_acc = 1'b0; inc_acc = 1'b0;
        md = 0; mb = 0;
        apply(0, 0, 0, 3, 1, "R1 B cleared, 0-0");
        apply(1, 0, 0, 6, 0, "R1 load 0+0");
    endtask

    task automatic t_bload();
        apply(0, 0, 1, 5, 0, "R8 B load");
        apply(1, 0, 0, 9, 0, "R8 R2 5+0");
        apply(1, 0, 0, 12, 0, "R8 B held, 5+5");
    endtask

    task automatic t_add();
        apply(0, 0, 1, 7, 0, "R8 B=7");
        apply(1, 0, 0, 0, 0, "R2 10+7 wraps");
        apply(0, 0, 1, 3, 0, "R8 B=3");
        apply(1, 0, 0, 0, 0, "R2 1+3");
        apply(0, 0, 1, 15, 0, "R8 B=15");
        apply(1, 0, 0, 0, 0, "R2 4+15");
    endtask

    task automatic t_sub();
        apply(0, 0, 1, 6, 1, "R8 B=6");
        apply(1, 0, 0, 0, 1, "R3 3-6 borrow");
        apply(1, 0, 0, 0, 1, "R3 13-6");
        apply(0, 0, 1, 7, 1, "R8 B=7");
        apply(1, 0, 0, 0, 1, "R3 7-7 equal");
        apply(1, 0, 0, 0, 1, "R3 0-7");
    endtask

    task automatic t_inc();
        apply(0, 1, 0, 9, 1, "R5 inc mode 1");
        apply(0, 1, 0, 2, 0, "R5 inc mode 0");
        while (md != MASK) begin
            apply(0, 1, 0, md ^ 5, md & 1, "R5 inc climb");
        end
        apply(0, 1, 0, 11, 1, "R5 wrap to 0");
    endtask

    task automatic t_prio();
        apply(0, 0, 1, 4, 0, "R8 B=4");
        apply(1, 1, 0, 0, 0, "R6 load over inc add");
        apply(1, 1, 0, 0, 1, "R6 load over inc sub");
    endtask

    task automatic t_hold();
        apply(0, 0, 0, 13, 1, "R7 hold sub");
        apply(0, 0, 0, 2, 0, "R7 hold add");
        apply(0, 0, 1, 9, 1, "R7 hold with B load");
        apply(1, 0, 0, 0, 0, "R7 R8 verify B=9");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bload();
        t_add();
        t_sub();
        t_inc();
        t_prio();
        t_hold();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule